// File: doc/BRIEF.md
# Nibble-Wide Four-Wire Host Handshake Port

This block is the device end of a fully asynchronous link to a host processor. Bytes cross a shared 4-bit data bus as two nibbles, low nibble first. Two pairs of active-low handshake lines control the bus, one pair for each direction. The download pair carries traffic from host to device and the upload pair carries traffic from device to host. Each nibble uses a four-phase request/accept exchange. The host and device clocks are unrelated, so both incoming handshake lines pass through a two-flop synchroniser before any decision uses them.

The first byte of every download is a control byte. With bit 7 clear, the transfer is a data packet: bits 4:0 give the number of data bytes, and the control byte plus its data are written into a packet buffer. With bit 7 set, the transfer is a memory command: bit 6 selects write (1) or read (0) and bits 5:0 give the address. A write carries one more byte and is answered by nothing. A read is answered by an upload of two bytes, the echoed control byte followed by the memory contents.

A separate input reports that a received radio packet is waiting in the buffer. While this input is high, the port does not accept host downloads. It uploads the waiting packet first, and only then answers a host request that is still being held.

Inside the block, bytes reach the upload nibble engine over a valid/ready stream. A byte is taken only when the engine is idle, and the sequencer holds valid and data stable until then. The buffer and memory ports are plain strobes with no back-pressure: a write is one cycle, and read data is taken in the cycle the address or read strobe is presented.

Top module: `nibble_host_port`

## Requirements
- R1: After reset, `dl_ack_n` and `ul_req_n` are high, `bus_oe` is low, and none of `buf_we`, `mem_wr`, `mem_rd`, `dl_done` or `ul_done` is asserted.
- R2: Download runs per nibble as follows:
  - the host drops `dl_req_n`;
  - the port drops `dl_ack_n`;
  - the host places the nibble on `bus_i` and raises `dl_req_n`;
  - the port latches the nibble and raises `dl_ack_n`.
  The first nibble of each byte is bits 3:0 and the second is bits 7:4.
- R3: Upload runs per nibble as follows:
  - the port drops `ul_req_n`;
  - the host drops `ul_ack_n`;
  - the port places the nibble on `bus_o` and raises `ul_req_n` in the same cycle;
  - the host raises `ul_ack_n`.
  Bits 3:0 go first, then bits 7:4.
- R4: `bus_oe` is high from the cycle the first upload nibble is driven until the last nibble of the upload has been released by the host. It is low at all other times, including during downloads.
- R5: A control byte with bit 7 = 0 starts a data packet. Its count field is bits 4:0. A count of 0 ends the download after the control byte alone, and a count above 27 is treated as 27. The control byte goes to buffer address 0 and data byte k goes to address k. `dl_done` pulses for one cycle after the last byte has been written.
- R6: A control byte with bit 7 = 1 and bit 6 = 1 is a memory write. After the following byte arrives, `mem_wr` pulses for exactly one cycle, with `mem_addr` equal to control bits 5:0 and `mem_wdata` equal to the second byte. There is no buffer write and no upload.
- R7: A control byte with bit 7 = 1 and bit 6 = 0 is a memory read. `mem_rd` pulses once, with `mem_addr` equal to control bits 5:0, and `mem_rdata` is taken in that cycle. Two bytes are then uploaded: the control byte, then the captured data.
- R8: While `rx_pend` is high and the port is idle, it does not assert `dl_ack_n`, even if a host request is held. Instead it uploads the buffer packet, whose length comes from bits 4:0 of buffer byte 0 under the rules of R5. It then pulses `ul_done`. A request still held afterwards is served as a normal download.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dl_req_n | input | 1 | Host download request, active low |
| dl_ack_n | output | 1 | Device download accept, active low |
| ul_req_n | output | 1 | Device upload request, active low |
| ul_ack_n | input | 1 | Host upload accept, active low |
| bus_i | input | 4 | Data bus as seen at the pins |
| bus_o | output | 4 | Nibble driven during upload |
| bus_oe | output | 1 | Enable for the tri-state bus driver |
| buf_we | output | 1 | Packet buffer write strobe |
| buf_addr | output | IDX_W | Packet buffer address (write and read) |
| buf_wdata | output | 8 | Packet buffer write data |
| buf_rdata | input | 8 | Packet buffer read data for `buf_addr`, same cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 6 | Memory address from the control byte |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with `mem_rd` |
| rx_pend | input | 1 | A received packet waits in the buffer |
| dl_done | output | 1 | One-cycle pulse: data packet download complete |
| ul_done | output | 1 | One-cycle pulse: buffer packet upload complete |

## Verification
A handshake edge from the host reaches the port's logic two clock edges later, through the synchroniser. The port's answer appears on the following edge, so about three cycles separate host and device edges. The bench therefore waits on handshake levels inside bounded polls at the falling clock edge, and never assumes a fixed count. Completion pulses and strobes last one cycle, so edge monitors count them, and each test compares the counts only after its handshake sequence has finished. The deferral test holds the request for twenty cycles before it samples `dl_ack_n`, which is far longer than the three-cycle response path. `bus_oe` is sampled at the moment each uploaded nibble is read, and again after the host has released its last accept.

// File: rtl/nhp_pkg.sv
package nhp_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DL,
    S_MR,
    S_MR_ECHO,
    S_MR_DATA,
    S_UL_SEND,
    S_UL_DRAIN,
    S_COOL
  } seq_state_t;

  typedef struct packed {
    logic       is_mem;
    logic       is_wr;
    logic [5:0] addr;
    logic [4:0] cnt;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [7:0] b);
    ctl_t c;
    c.is_mem = b[7];
    c.is_wr  = b[6];
    c.addr   = b[5:0];
    c.cnt    = b[4:0];
    return c;
  endfunction

endpackage

// File: rtl/nhp_sync.sv
module nhp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/nhp_dl_nib.sv
module nhp_dl_nib (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       req_act,
  input  logic [3:0] bus_i,
  output logic       ack_n,
  output logic       byte_vld,
  output logic [7:0] byte_q
);
  typedef enum logic {D_IDLE, D_ACK} dl_st_t;
  dl_st_t     st;
  logic       hi;
  logic [3:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= D_IDLE;
      ack_n    <= 1'b1;
      hi       <= 1'b0;
      lo_q     <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      case (st)
        D_IDLE: begin
          if (!en) hi <= 1'b0;
          if (en && req_act) begin
            ack_n <= 1'b0;
            st    <= D_ACK;
          end
        end
        D_ACK: begin
          if (!req_act) begin
            if (!hi) begin
              lo_q <= bus_i;
              hi   <= 1'b1;
            end else begin
              byte_q   <= {bus_i, lo_q};
              byte_vld <= 1'b1;
              hi       <= 1'b0;
            end
            ack_n <= 1'b1;
            st    <= D_IDLE;
          end
        end
        default: st <= D_IDLE;
      endcase
    end
  end

  // R2: accept only falls after a seen request, and only rises after its release
  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(req_act));
  a_r2_ack_rise_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> !$past(req_act));
endmodule

// File: rtl/nhp_ul_nib.sv
module nhp_ul_nib (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  output logic       in_rdy,
  input  logic [7:0] in_byte,
  input  logic       ack_act,
  output logic       req_n,
  output logic [3:0] nib_o,
  output logic       drive_now
);
  typedef enum logic [1:0] {U_IDLE, U_REQ, U_REL} ul_st_t;
  ul_st_t     st;
  logic       hi;
  logic [7:0] byte_q;

  assign in_rdy    = (st == U_IDLE);
  assign drive_now = (st == U_REQ) && ack_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= U_IDLE;
      hi     <= 1'b0;
      byte_q <= '0;
      req_n  <= 1'b1;
      nib_o  <= '0;
    end else begin
      case (st)
        U_IDLE: begin
          if (in_vld) begin
            byte_q <= in_byte;
            hi     <= 1'b0;
            req_n  <= 1'b0;
            st     <= U_REQ;
          end
        end
        U_REQ: begin
          if (ack_act) begin
            nib_o <= hi ? byte_q[7:4] : byte_q[3:0];
            req_n <= 1'b1;
            st    <= U_REL;
          end
        end
        U_REL: begin
          if (!ack_act) begin
            if (!hi) begin
              hi    <= 1'b1;
              req_n <= 1'b0;
              st    <= U_REQ;
            end else begin
              st <= U_IDLE;
            end
          end
        end
        default: st <= U_IDLE;
      endcase
    end
  end

  // R3: request rises only once the host accept was seen
  a_r3_req_rise_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_n) |-> $past(ack_act));
endmodule

// File: rtl/nibble_host_port.sv
module nibble_host_port
  import nhp_pkg::*;
#(
  parameter  int MAX_DATA = 27,
  localparam int IDX_W    = $clog2(MAX_DATA + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dl_req_n,
  output logic             dl_ack_n,
  output logic             ul_req_n,
  input  logic             ul_ack_n,
  input  logic [3:0]       bus_i,
  output logic [3:0]       bus_o,
  output logic             bus_oe,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_addr,
  output logic [7:0]       buf_wdata,
  input  logic [7:0]       buf_rdata,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [5:0]       mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             rx_pend,
  output logic             dl_done,
  output logic             ul_done
);

  logic [1:0] sync_q;
  logic       dl_req_act, ul_ack_act;

  nhp_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dl_req_n, ul_ack_n}), .q(sync_q)
  );
  assign dl_req_act = ~sync_q[1];
  assign ul_ack_act = ~sync_q[0];

  seq_state_t       st;
  logic [7:0]       ctl;
  logic [IDX_W-1:0] cnt, need;
  logic [7:0]       rdq;
  logic             upk;

  logic       dl_vld;
  logic [7:0] dl_byte;
  ctl_t       dc;

  nhp_dl_nib u_dl (
    .clk(clk), .rst_n(rst_n), .en(st == S_DL), .req_act(dl_req_act),
    .bus_i(bus_i), .ack_n(dl_ack_n), .byte_vld(dl_vld), .byte_q(dl_byte)
  );
  assign dc = ctl_decode(dl_byte);

  logic       ul_vld, ul_rdy, drive_now;
  logic [7:0] ul_byte;

  always_comb begin
    ul_vld  = 1'b0;
    ul_byte = buf_rdata;
    case (st)
      S_MR_ECHO: begin ul_vld = 1'b1; ul_byte = ctl; end
      S_MR_DATA: begin ul_vld = 1'b1; ul_byte = rdq; end
      S_UL_SEND: begin ul_vld = 1'b1; ul_byte = buf_rdata; end
      default:   ;
    endcase
  end

  nhp_ul_nib u_ul (
    .clk(clk), .rst_n(rst_n), .in_vld(ul_vld), .in_rdy(ul_rdy),
    .in_byte(ul_byte), .ack_act(ul_ack_act), .req_n(ul_req_n),
    .nib_o(bus_o), .drive_now(drive_now)
  );

  function automatic logic [IDX_W-1:0] clampc(input logic [4:0] c);
    if (int'(c) > MAX_DATA) return IDX_W'(MAX_DATA);
    else                    return IDX_W'(c);
  endfunction

  logic [IDX_W-1:0] dl_need;
  logic             ul_last;
  assign dl_need = clampc(dc.cnt);
  assign ul_last = (buf_addr == '0) ? (clampc(buf_rdata[4:0]) == '0)
                                    : (buf_addr == need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ctl       <= '0;
      cnt       <= '0;
      need      <= '0;
      rdq       <= '0;
      upk       <= 1'b0;
      bus_oe    <= 1'b0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dl_done   <= 1'b0;
      ul_done   <= 1'b0;
    end else begin
      buf_we  <= 1'b0;
      mem_wr  <= 1'b0;
      mem_rd  <= 1'b0;
      dl_done <= 1'b0;
      ul_done <= 1'b0;
      if (drive_now) bus_oe <= 1'b1;
      case (st)
        S_IDLE: begin
          if (rx_pend) begin
            buf_addr <= '0;
            upk      <= 1'b1;
            st       <= S_UL_SEND;
          end else if (dl_req_act) begin
            cnt <= '0;
            st  <= S_DL;
          end
        end
        S_DL: begin
          if (dl_vld) begin
            if (cnt == '0) begin
              ctl      <= dl_byte;
              mem_addr <= dc.addr;
              if (!dc.is_mem) begin
                buf_we    <= 1'b1;
                buf_addr  <= '0;
                buf_wdata <= dl_byte;
                need      <= dl_need;
                if (dl_need == '0) begin
                  dl_done <= 1'b1;
                  st      <= S_IDLE;
                end else begin
                  cnt <= IDX_W'(1);
                end
              end else if (dc.is_wr) begin
                need <= IDX_W'(1);
                cnt  <= IDX_W'(1);
              end else begin
                mem_rd <= 1'b1;
                st     <= S_MR;
              end
            end else if (ctl[7]) begin
              mem_wdata <= dl_byte;
              mem_wr    <= 1'b1;
              st        <= S_IDLE;
            end else begin
              buf_we    <= 1'b1;
              buf_addr  <= cnt;
              buf_wdata <= dl_byte;
              if (cnt == need) begin
                dl_done <= 1'b1;
                st      <= S_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        end
        S_MR: begin
          rdq <= mem_rdata;
          st  <= S_MR_ECHO;
        end
        S_MR_ECHO: if (ul_rdy) st <= S_MR_DATA;
        S_MR_DATA: begin
          if (ul_rdy) begin
            upk <= 1'b0;
            st  <= S_UL_DRAIN;
          end
        end
        S_UL_SEND: begin
          if (ul_rdy) begin
            if (buf_addr == '0) need <= clampc(buf_rdata[4:0]);
            if (ul_last) st <= S_UL_DRAIN;
            else         buf_addr <= buf_addr + 1'b1;
          end
        end
        S_UL_DRAIN: begin
          if (ul_rdy) begin
            bus_oe  <= 1'b0;
            ul_done <= upk;
            st      <= S_COOL;
          end
        end
        S_COOL:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3/R4: each nibble is driven with the enable already on when the request rises
  a_r4_nibble_driven: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ul_req_n) |-> bus_oe);
  // R4: the bus is only driven while an upload is in progress
  a_r4_oe_scope: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (st inside {S_MR_ECHO, S_MR_DATA, S_UL_SEND, S_UL_DRAIN}));
  // R5: buffer writes stay inside the packet
  a_r5_we_range: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (int'(buf_addr) <= MAX_DATA));
  // R6: a memory write is a single-cycle strobe
  a_r6_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  // R8: a pending packet wins over any host request seen while idle
  a_r8_defer: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rx_pend) |=> (st == S_UL_SEND));
endmodule

// File: tb/sim_nibble_host_port.sv
module sim_nibble_host_port;
  localparam int MAX_DATA = 27;
  localparam int IDX_W    = $clog2(MAX_DATA + 1);
  localparam int LIM      = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             dl_req_n = 1'b1, ul_ack_n = 1'b1, rx_pend = 1'b0;
  logic [3:0]       bus_i = '0;
  logic             dl_ack_n, ul_req_n, bus_oe, buf_we, mem_rd, mem_wr, dl_done, ul_done;
  logic [3:0]       bus_o;
  logic [IDX_W-1:0] buf_addr;
  logic [7:0]       buf_wdata, buf_rdata, mem_wdata, mem_rdata;
  logic [5:0]       mem_addr;

  nibble_host_port #(.MAX_DATA(MAX_DATA)) u0 (
    .clk(clk), .rst_n(rst_n), .dl_req_n(dl_req_n), .dl_ack_n(dl_ack_n),
    .ul_req_n(ul_req_n), .ul_ack_n(ul_ack_n), .bus_i(bus_i), .bus_o(bus_o),
    .bus_oe(bus_oe), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_pend(rx_pend),
    .dl_done(dl_done), .ul_done(ul_done)
  );

  // buffer and memory models
  logic [7:0]       bmem [32];
  logic             pre_we = 1'b0;
  logic [4:0]       pre_a  = '0;
  logic [7:0]       pre_d  = '0;
  always @(posedge clk) begin
    if (buf_we)      bmem[5'(buf_addr)] <= buf_wdata;
    else if (pre_we) bmem[pre_a]        <= pre_d;
  end
  assign buf_rdata = bmem[5'(buf_addr)];
  assign mem_rdata = {mem_addr, 2'b01};

  int n_dl_done = 0, n_ul_done = 0, n_wr = 0, n_rd = 0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  always @(posedge clk) begin
    if (dl_done) n_dl_done <= n_dl_done + 1;
    if (ul_done) n_ul_done <= n_ul_done + 1;
    if (mem_wr) begin n_wr <= n_wr + 1; wr_addr <= mem_addr; wr_data <= mem_wdata; end
    if (mem_rd) begin n_rd <= n_rd + 1; rd_addr <= mem_addr; end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_dl_ack(input logic v, input string req);
    int n = 0;
    while (dl_ack_n !== v && n < LIM) begin @(negedge clk); n++; end
    if (dl_ack_n !== v) chk(req, 32'(dl_ack_n), 32'(v));
  endtask

  task automatic wait_ul_req(input logic v, input string req);
    int n = 0;
    while (ul_req_n !== v && n < LIM) begin @(negedge clk); n++; end
    if (ul_req_n !== v) chk(req, 32'(ul_req_n), 32'(v));
  endtask

  task automatic host_send(input logic [7:0] b);
    for (int k = 0; k < 2; k++) begin
      dl_req_n = 1'b0;
      wait_dl_ack(1'b0, "R2 accept low");
      bus_i    = (k == 0) ? b[3:0] : b[7:4];
      dl_req_n = 1'b1;
      wait_dl_ack(1'b1, "R2 accept high");
      if (bus_oe !== 1'b0) chk("R4 oe during download", 32'(bus_oe), 0);
    end
  endtask

  task automatic host_recv(output logic [7:0] b);
    logic [3:0] lo = '0;
    b = '0;
    for (int k = 0; k < 2; k++) begin
      wait_ul_req(1'b0, "R3 request low");
      ul_ack_n = 1'b0;
      wait_ul_req(1'b1, "R3 request high");
      if (bus_oe !== 1'b1) chk("R4 oe while nibble shown", 32'(bus_oe), 1);
      if (k == 0) lo = bus_o;
      else        b  = {bus_o, lo};
      @(negedge clk);
      ul_ack_n = 1'b1;
    end
  endtask

  task automatic preload(input logic [4:0] a, input logic [7:0] d);
    pre_a = a; pre_d = d; pre_we = 1'b1;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 dl_ack_n", 32'(dl_ack_n), 1);
    chk("R1 ul_req_n", 32'(ul_req_n), 1);
    chk("R1 bus_oe",   32'(bus_oe),   0);
    chk("R1 strobes",  32'({buf_we, mem_wr, mem_rd, dl_done, ul_done}), 0);
  endtask

  task automatic t_data_pkt();
    int d0 = n_dl_done;
    host_send(8'h03); host_send(8'hA1); host_send(8'hB2); host_send(8'hC3);
    settle();
    chk("R5 ctl at 0",  32'(bmem[0]), 32'h03);
    chk("R2 R5 byte1",  32'(bmem[1]), 32'hA1);
    chk("R5 byte3",     32'(bmem[3]), 32'hC3);
    chk("R5 dl_done",   32'(n_dl_done - d0), 1);
    chk("R4 oe idle",   32'(bus_oe), 0);
  endtask

  task automatic t_len_clamp();
    int d0 = n_dl_done;
    host_send(8'h1F);
    for (int i = 1; i <= 27; i++) host_send(8'(8'h40 + i));
    settle();
    chk("R5 clamp done", 32'(n_dl_done - d0), 1);
    chk("R5 last byte",  32'(bmem[27]), 32'h5B);
  endtask

  task automatic t_len_zero();
    int d0 = n_dl_done;
    host_send(8'h00);
    settle();
    chk("R5 zero count done", 32'(n_dl_done - d0), 1);
    chk("R5 zero ctl",        32'(bmem[0]), 32'h00);
  endtask

  task automatic t_mem_write();
    int w0 = n_wr, d0 = n_dl_done;
    logic [7:0] b1 = bmem[1];
    host_send(8'hC5); host_send(8'h7E);
    settle();
    chk("R6 one strobe",  32'(n_wr - w0), 1);
    chk("R6 addr",        32'(wr_addr), 32'h05);
    chk("R6 data",        32'(wr_data), 32'h7E);
    chk("R6 no done",     32'(n_dl_done - d0), 0);
    chk("R6 no upload",   32'(ul_req_n), 1);
    chk("R6 buffer kept", 32'(bmem[1]), 32'(b1));
  endtask

  task automatic t_mem_read();
    logic [7:0] e, v;
    int r0 = n_rd;
    host_send(8'h8A);
    host_recv(e);
    host_recv(v);
    settle();
    chk("R7 one read", 32'(n_rd - r0), 1);
    chk("R7 addr",     32'(rd_addr), 32'h0A);
    chk("R3 R7 echo",  32'(e), 32'h8A);
    chk("R3 R7 data",  32'(v), 32'h29);
    chk("R4 oe off",   32'(bus_oe), 0);
  endtask

  task automatic t_defer();
    logic [7:0] r;
    int u0 = n_ul_done, d0 = n_dl_done, n = 0;
    preload(5'd0, 8'h02); preload(5'd1, 8'h11); preload(5'd2, 8'h22);
    rx_pend  = 1'b1;
    dl_req_n = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 no accept",  32'(dl_ack_n), 1);
    chk("R8 upload req", 32'(ul_req_n), 0);
    host_recv(r); chk("R8 b0", 32'(r), 32'h02);
    host_recv(r); chk("R8 b1", 32'(r), 32'h11);
    host_recv(r); chk("R8 b2", 32'(r), 32'h22);
    while (ul_done !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
    rx_pend = 1'b0;
    @(negedge clk);
    chk("R8 ul_done",  32'(n_ul_done - u0), 1);
    chk("R4 oe after", 32'(bus_oe), 0);
    host_send(8'h01); host_send(8'h99);
    settle();
    chk("R8 held request served", 32'(bmem[1]), 32'h99);
    chk("R8 dl_done",             32'(n_dl_done - d0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_data_pkt();
    t_len_zero();
    t_mem_write();
    t_mem_read();
    t_len_clamp();
    t_defer();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule